// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single load reservation of one hardware thread and decides whether a store-conditional may commit. The requester issues load-reserved and store-conditional requests. Each request carries a word address, and a store-conditional also carries its store data. A load-reserved reads the word at its address, returns it to the requester, and arms a reservation on that word. A store-conditional writes its data only while the reservation is live and covers the same word. It then reports zero on success and a nonzero failure code otherwise.

Other bus agents report their writes on a snoop port. A snooped write to any byte of the reserved word breaks the reservation. A load-reserved followed by a store-conditional therefore gives the caller a compare-and-swap, and each request needs only one address and at most one data operand. The memory is external, single-cycle and synchronous. The block drives read and write strobes in the cycle it accepts a request. It presents the response one cycle later, when read data returns.

Top module: `lrsc_monitor`

## Requirements
- R1: A load-reserved to an aligned address (low two bits zero) asserts the read strobe in its request cycle. One cycle later the response is valid and returns the memory word as the response data.
- R2: A store-conditional that finds a live reservation on its word asserts the write strobe in its request cycle, with the request address and data. One cycle later its response data is 0.
- R3: A store-conditional with no live reservation on its word asserts no write strobe and leaves memory unchanged. Its response data is FAIL_CODE (default 1, nonzero).
- R4: Every aligned store-conditional clears the reservation, whether it succeeds or fails. A second store-conditional to the same word then fails.
- R5: A snooped write to any byte address inside the reserved word clears the reservation. A snooped write to a different word leaves it intact.
- R6: A snooped write to the reserved word in the same cycle as a store-conditional to that word makes the store-conditional fail.
- R7: A new load-reserved replaces any earlier reservation, so a later store-conditional to the old word fails. If a load-reserved and a snoop arrive in the same cycle, the load-reserved decides the new reservation.
- R8: A misaligned request asserts neither strobe and leaves the reservation unchanged. One cycle later it responds with the misalign flag set and response data 0.
- R9: After reset no reservation is held and no response is valid. A store-conditional issued first after reset fails.
- R10: Each request produces exactly one valid response, in the cycle after the request. The misalign flag is 0 for aligned requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data for a store-conditional |
| snp_valid | input | 1 | Another agent writes memory this cycle |
| snp_addr | input | ADDR_W | Byte address of the snooped write |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read |
| rsp_valid | output | 1 | Response present |
| rsp_misalign | output | 1 | Request was misaligned |
| rsp_data | output | DATA_W | Loaded word, or store-conditional result code |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, and FAIL_CODE of 1. It confines addresses to sixteen words, so random load-reserved, store-conditional and snoop traffic hits the reserved word often. That confinement makes the interesting cases frequent: a snoop and a store-conditional to the same word in one cycle, a snoop that lands in the reserved word at a different byte, replaced reservations, and misaligned requests against a live reservation.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } lrsc_kind_e;

  typedef struct packed {
    logic       valid;
    logic       misalign;
    lrsc_kind_e kind;
    logic       sc_ok;
  } lrsc_rsp_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode #(
  parameter int OFS_W = 2
) (
  input  logic             req_valid,
  input  logic             req_is_sc,
  input  logic [OFS_W-1:0] req_ofs,
  output logic             lr_go,
  output logic             sc_go,
  output logic             misalign
);

  logic aligned;

  always_comb begin
    aligned  = (req_ofs == '0);
    misalign = req_valid && !aligned;
    lr_go    = req_valid && aligned && !req_is_sc;
    sc_go    = req_valid && aligned && req_is_sc;
  end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_go,
  input  logic              sc_go,
  input  logic [WORD_W-1:0] req_word,
  input  logic              snp_valid,
  input  logic [WORD_W-1:0] snp_word,
  output logic              sc_hit
);

  logic              held_q, held_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              snp_kill;
  logic              upd_en;

  always_comb begin
    snp_kill = held_q && snp_valid && (snp_word == word_q);
    sc_hit   = held_q && (req_word == word_q) && !snp_kill;
    held_d   = held_q;
    word_d   = word_q;
    if (lr_go) begin
      held_d = 1'b1;
      word_d = req_word;
    end else if (sc_go || snp_kill) begin
      held_d = 1'b0;
    end
    upd_en = lr_go || sc_go || snp_kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else if (upd_en) begin
      held_q <= held_d;
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/lrsc_resp.sv
module lrsc_resp
  import lrsc_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] FAIL_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              misalign,
  input  logic              sc_go,
  input  logic              sc_hit,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_misalign,
  output logic [DATA_W-1:0] rsp_data
);

  lrsc_rsp_t rsp_q, rsp_d;

  always_comb begin
    rsp_d.valid    = req_valid;
    rsp_d.misalign = misalign;
    rsp_d.kind     = sc_go ? KIND_STORE : KIND_LOAD;
    rsp_d.sc_ok    = sc_go && sc_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else begin
      rsp_q <= rsp_d;
    end
  end

  always_comb begin
    rsp_valid    = rsp_q.valid;
    rsp_misalign = rsp_q.valid && rsp_q.misalign;
    if (!rsp_q.valid || rsp_q.misalign) begin
      rsp_data = '0;
    end else if (rsp_q.kind == KIND_LOAD) begin
      rsp_data = mem_rdata;
    end else if (rsp_q.sc_ok) begin
      rsp_data = '0;
    end else begin
      rsp_data = FAIL_CODE;
    end
  end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] FAIL_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_sc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_misalign,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int OFS_W  = $clog2(DATA_W / 8);
  localparam int WORD_W = ADDR_W - OFS_W;

  logic lr_go, sc_go, misalign, sc_hit;

  lrsc_decode #(.OFS_W(OFS_W)) u_decode (
    .req_valid (req_valid),
    .req_is_sc (req_is_sc),
    .req_ofs   (req_addr[OFS_W-1:0]),
    .lr_go     (lr_go),
    .sc_go     (sc_go),
    .misalign  (misalign)
  );

  lrsc_resv #(.WORD_W(WORD_W)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .lr_go     (lr_go),
    .sc_go     (sc_go),
    .req_word  (req_addr[ADDR_W-1:OFS_W]),
    .snp_valid (snp_valid),
    .snp_word  (snp_addr[ADDR_W-1:OFS_W]),
    .sc_hit    (sc_hit)
  );

  lrsc_resp #(.DATA_W(DATA_W), .FAIL_CODE(FAIL_CODE)) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .misalign     (misalign),
    .sc_go        (sc_go),
    .sc_hit       (sc_hit),
    .mem_rdata    (mem_rdata),
    .rsp_valid    (rsp_valid),
    .rsp_misalign (rsp_misalign),
    .rsp_data     (rsp_data)
  );

  always_comb begin
    mem_rd_en = lr_go;
    mem_wr_en = sc_go && sc_hit;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
  end

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] FAIL_CODE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_sc,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rsp_valid,
  input logic              rsp_misalign,
  input logic [DATA_W-1:0] rsp_data
);

  // R8
  misalign_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |-> (!mem_rd_en && !mem_wr_en));

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  sc_pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (rsp_valid && rsp_data == '0));

  // R2
  wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (req_valid && req_is_sc && mem_addr == req_addr && mem_wdata == req_wdata));

  // R3
  sc_fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_sc && req_addr[1:0] == 2'b00 && !mem_wr_en) |=> (rsp_data == FAIL_CODE));

  // R4
  sc_twice_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_sc && req_addr[1:0] == 2'b00) |=> !mem_wr_en);

  // R1
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R1
  rd_only_for_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (req_valid && !req_is_sc));

  // R10
  aligned_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] == 2'b00) |=> !rsp_misalign);

endmodule

bind lrsc_monitor lrsc_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAIL_CODE(FAIL_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
  .req_addr(req_addr), .req_wdata(req_wdata), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign), .rsp_data(rsp_data)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;

  localparam logic [31:0] FAILV = 32'd1;

  logic        clk, rst_n;
  logic        req_valid, req_is_sc, snp_valid;
  logic [31:0] req_addr, req_wdata, snp_addr;
  logic        mem_rd_en, mem_wr_en, rsp_valid, rsp_misalign;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_data;

  logic [31:0] mem   [16];
  logic [31:0] mdl   [16];
  logic        m_held;
  logic [3:0]  m_word;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  lrsc_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
    .req_addr(req_addr), .req_wdata(req_wdata), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign), .rsp_data(rsp_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[5:2]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[5:2]];
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(logic [3:0] w, logic [1:0] b);
    return {26'h0, w, b};
  endfunction

  // One request (optionally with a snoop in the same cycle), then one idle cycle.
  task automatic do_req(bit sc, logic [31:0] a, logic [31:0] d, bit sv, logic [31:0] sa);
    bit al, ok, kill;
    logic [31:0] exp_data;
    @(negedge clk);
    req_valid = 1; req_is_sc = sc; req_addr = a; req_wdata = d;
    snp_valid = sv; snp_addr = sa;
    al   = (a[1:0] == 2'b00);
    kill = m_held && sv && (sa[5:2] == m_word) && (sa[31:6] == 0);
    ok   = sc && al && m_held && (a[5:2] == m_word) && !kill;
    #1;
    chk(sc ? "R2 wr strobe" : "R1 rd strobe", {31'b0, sc ? mem_wr_en : mem_rd_en},
        {31'b0, sc ? ok : al});
    if (!al) chk("R8 no strobe", {30'b0, mem_rd_en, mem_wr_en}, 32'h0);
    if (!al)        exp_data = 32'h0;
    else if (!sc)   exp_data = mdl[a[5:2]];
    else if (ok)    exp_data = 32'h0;
    else            exp_data = FAILV;
    if (ok) mdl[a[5:2]] = d;
    if (al && !sc) begin m_held = 1; m_word = a[5:2]; end
    else if ((al && sc) || kill) m_held = 0;
    @(negedge clk);
    req_valid = 0; snp_valid = 0;
    #1;
    chk("R10 rsp valid", {31'b0, rsp_valid}, 32'h1);
    chk(al ? "R10 misalign flag" : "R8 misalign flag", {31'b0, rsp_misalign}, {31'b0, !al});
    chk(!sc ? "R1 load data" : (ok ? "R2 sc pass" : "R3 sc fail"), rsp_data, exp_data);
  endtask

  task automatic do_snoop(logic [31:0] sa);
    @(negedge clk);
    snp_valid = 1; snp_addr = sa;
    if (m_held && sa[5:2] == m_word && sa[31:6] == 0) m_held = 0;
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10 no rsp on snoop", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA000_0000 + i * 32'h0101;
      mdl[i] = mem[i];
    end
    m_held = 0; m_word = 0;
    req_valid = 0; req_is_sc = 0; req_addr = 0; req_wdata = 0;
    snp_valid = 0; snp_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 rsp idle in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1;
    // R9: first SC after reset fails
    do_req(1, mk_addr(0, 0), 32'h1111, 0, 0);
    // R1/R2 basic pair
    do_req(0, mk_addr(3, 0), 0, 0, 0);
    do_req(1, mk_addr(3, 0), 32'hCAFE_0003, 0, 0);
    do_req(0, mk_addr(3, 0), 0, 0, 0);           // R1 reads back new value
    // R4 second SC fails
    do_req(1, mk_addr(3, 0), 32'hDEAD, 0, 0);
    // R5 snoop other word keeps, snoop byte in word kills
    do_req(0, mk_addr(5, 0), 0, 0, 0);
    do_snoop(mk_addr(6, 0));
    do_req(1, mk_addr(5, 0), 32'h5555, 0, 0);
    do_req(0, mk_addr(5, 0), 0, 0, 0);
    do_snoop(mk_addr(5, 3));
    do_req(1, mk_addr(5, 0), 32'h6666, 0, 0);
    // R6 snoop same cycle as SC
    do_req(0, mk_addr(7, 0), 0, 0, 0);
    do_req(1, mk_addr(7, 0), 32'h7777, 1, mk_addr(7, 1));
    // R7 replacement, and LR+snoop same cycle
    do_req(0, mk_addr(8, 0), 0, 0, 0);
    do_req(0, mk_addr(9, 0), 0, 1, mk_addr(9, 0));
    do_req(1, mk_addr(8, 0), 32'h8888, 0, 0);
    do_req(0, mk_addr(9, 0), 0, 0, 0);
    do_req(1, mk_addr(9, 0), 32'h9999, 0, 0);
    // R8 misaligned keeps reservation
    do_req(0, mk_addr(10, 0), 0, 0, 0);
    do_req(1, mk_addr(10, 2), 32'hAAAA, 0, 0);
    do_req(0, mk_addr(11, 1), 0, 0, 0);
    do_req(1, mk_addr(10, 0), 32'hABAB, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [3:0] w;
      logic [1:0] b;
      k = $urandom_range(0, 9);
      w = ($urandom_range(0, 1) == 1 && m_held) ? m_word : 4'($urandom_range(0, 15));
      b = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      if (k < 4)
        do_req(0, mk_addr(w, b), 0, $urandom_range(0, 3) == 0,
               mk_addr(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))));
      else if (k < 8)
        do_req(1, mk_addr(w, b), $urandom, $urandom_range(0, 3) == 0,
               mk_addr(($urandom_range(0, 1) == 1) ? w : 4'($urandom_range(0, 15)),
                       2'($urandom_range(0, 3))));
      else
        do_snoop(mk_addr(($urandom_range(0, 1) == 1) ? m_word : 4'($urandom_range(0, 15)),
                         2'($urandom_range(0, 3))));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule